// File: doc/BRIEF.md
# PC Card Configuration Register File

This block sits on the attribute-memory side of a removable ATA storage card and holds the small set of card configuration registers that a host socket driver programs at insertion time. The host reaches it through a byte-wide attribute port. Addresses below a fixed base offset read from a short card-information ROM. At the base and the next three even offsets sit four registers: an option register that selects the addressing mode and holds a soft-reset bit, a configuration status register, a pin replacement register and a socket/copy register that always reads zero.

The block also keeps two bits of the host-side device control register: interrupt enable and software reset. It merges them with the drive's interrupt flag and the option soft-reset bit into one interrupt line. The line is high only when the drive flag is clear and none of the three gating sources is set. A write that sets either soft-reset bit sends a one-cycle pulse to the rest of the card. The same write clears the other configuration registers.

Top module: `card_cfg_regs`

## Requirements
- R1: The socket/copy register at base+6 always reads 0x00, and writes to it change nothing. Every address at or above the base other than base+0, +2 and +4 reads 0x00.
- R2: A read at address i below the base returns (i*37+11) mod 256 when i < ROM_LEN (default 32), and 0x00 otherwise. Writes below the base have no effect.
- R3: A write to the option register at base+0 stores the data ANDed with 0xCF. The stored value reads back at base+0 in the following cycle.
- R4: A write to the status register at base+2 keeps bits 7 and 1 and loads bits 6, 5, 4 and 2 from the data. Bits 0 and 3 read 0. Bit 1 follows the drvIrq input one cycle later.
- R5: When the stored interrupt-enable bit is set, a status read returns bit 1 as 0. Otherwise the read returns the full register.
- R6: A pin replacement read at base+4 returns 0x0C ORed with the ready flag in bit 5 (0x20). Writes to base+4 leave the read value unchanged.
- R7: A status write whose bit 2 (power-down) differs from the stored bit 2 sets the ready flag.
- R8: irqLevel is 1 exactly when status bit 1 is 0, the stored interrupt-enable and software-reset bits are both 0, and option bit 7 is 0.
- R9: An option write with bit 7 set, or a device-control write with devCtlSrst set, raises softRst for exactly one cycle, in the cycle after the write. It clears the status bits other than bit 1, the ready flag and every configuration register that did not carry the reset bit. A register that carried the reset bit keeps its written value.
- R10: After a hard reset the option, status, ready flag and device-control bits are 0. The option register reads 0x00 (memory-mapped mode) and, with drvIrq low, irqLevel is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| attrAddr | input | ADDR_W | Attribute-space byte address |
| attrWrEn | input | 1 | Attribute write strobe |
| attrWrData | input | 8 | Attribute write data |
| devCtlWr | input | 1 | Host device-control write strobe |
| devCtlIen | input | 1 | Interrupt-enable bit of the device-control write |
| devCtlSrst | input | 1 | Software-reset bit of the device-control write |
| drvIrq | input | 1 | Drive interrupt level |
| attrRdData | output | 8 | Combinational attribute read data |
| irqLevel | output | 1 | Gated interrupt request |
| softRst | output | 1 | One-cycle card soft-reset pulse |

## Verification
The hardest state to reach is a soft reset that lands while the status and pin registers hold non-zero history. To reach it, the stimulus first sets all four loadable status bits and raises the ready flag by toggling power-down. It then writes the option reset bit and checks that the ready flag and status history are gone, that the option value itself survives and that softRst lasts exactly one cycle. Interrupt gating is exercised from the port side by combining each gating source with the drive flag in turn. Full sweeps cover every option and status write value, and a sweep covers every address below the base.

// File: rtl/card_cfg_pkg.sv
package card_cfg_pkg;

  // register field masks
  localparam logic [7:0] OPT_KEEP_MASK  = 8'hCF;
  localparam logic [7:0] STAT_HOLD_MASK = 8'h82;
  localparam logic [7:0] STAT_LOAD_MASK = 8'h74;
  localparam logic [7:0] PIN_FIXED_BITS = 8'h0C;

  localparam int STAT_BIT_IRQ   = 1;
  localparam int STAT_BIT_PWRDN = 2;
  localparam int PIN_BIT_READY  = 5;

  // register offsets from the attribute base
  localparam int OFS_OPT  = 0;
  localparam int OFS_STAT = 2;
  localparam int OFS_PIN  = 4;
  localparam int OFS_SOCK = 6;

  typedef enum logic [2:0] {
    SEL_ROM,
    SEL_OPT,
    SEL_STAT,
    SEL_PIN,
    SEL_NONE
  } rdSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic optWr;
    logic optRst;
    logic statWr;
    logic ctlWr;
    logic ctlRst;
  } cfgStrobe_t;

  // content of the card-information ROM model
  function automatic logic [7:0] infoByte(input int idx);
    return 8'((idx * 37 + 11) & 255);
  endfunction

endpackage

// File: rtl/card_cfg_info_rom.sv
module card_cfg_info_rom
  import card_cfg_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int ROM_LEN = 32
) (
  input  logic [ADDR_W-1:0] romAddr,
  output logic [7:0]        romData
);

  localparam int IDX_W = (ROM_LEN > 1) ? $clog2(ROM_LEN) : 1;
  localparam logic [ADDR_W-1:0] ROM_END = ADDR_W'(ROM_LEN);

  logic [7:0] romArr [ROM_LEN];

  for (genvar g = 0; g < ROM_LEN; g++) begin : g_rom
    assign romArr[g] = infoByte(g);
  end

  always_comb begin
    if (romAddr < ROM_END) romData = romArr[romAddr[IDX_W-1:0]];
    else                   romData = 8'h00;
  end

endmodule

// File: rtl/card_cfg_ctrl.sv
module card_cfg_ctrl
  import card_cfg_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int ATTR_BASE = 512
) (
  input  logic [ADDR_W-1:0] attrAddr,
  input  logic              attrWrEn,
  input  logic              optSrstBit,
  input  logic              devCtlWr,
  input  logic              devCtlSrst,
  output cfgStrobe_t        strobe,
  output rdSel_e            rdSel
);

  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(ATTR_BASE);

  logic              aboveBase;
  logic [ADDR_W-1:0] regOfs;

  always_comb begin
    aboveBase = (attrAddr >= BASE_A);
    regOfs    = attrAddr - BASE_A;
    if (!aboveBase)                        rdSel = SEL_ROM;
    else if (regOfs == ADDR_W'(OFS_OPT))   rdSel = SEL_OPT;
    else if (regOfs == ADDR_W'(OFS_STAT))  rdSel = SEL_STAT;
    else if (regOfs == ADDR_W'(OFS_PIN))   rdSel = SEL_PIN;
    else                                   rdSel = SEL_NONE; // socket/copy and holes
  end

  always_comb begin
    strobe.optWr  = attrWrEn && (rdSel == SEL_OPT);
    strobe.optRst = strobe.optWr && optSrstBit;
    strobe.statWr = attrWrEn && (rdSel == SEL_STAT);
    strobe.ctlWr  = devCtlWr;
    strobe.ctlRst = devCtlWr && devCtlSrst;
  end

endmodule

// File: rtl/card_cfg_dpath.sv
module card_cfg_dpath
  import card_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  cfgStrobe_t strobe,
  input  rdSel_e     rdSel,
  input  logic [7:0] wrData,
  input  logic       devCtlIen,
  input  logic       devCtlSrst,
  input  logic       drvIrq,
  input  logic [7:0] romData,
  output logic [7:0] rdData,
  output logic       irqLevel,
  output logic       softRst
);

  logic [7:0] optQ;
  logic [7:0] statQ;
  logic       readyQ;
  logic       ienQ;
  logic       srstQ;
  logic       softRstQ;
  logic       anyRst;

  assign anyRst = strobe.optRst || strobe.ctlRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      optQ     <= 8'h00;
      statQ    <= 8'h00;
      readyQ   <= 1'b0;
      ienQ     <= 1'b0;
      srstQ    <= 1'b0;
      softRstQ <= 1'b0;
    end else begin
      softRstQ <= anyRst;

      // option: the register carrying the reset bit keeps its value
      if (strobe.optWr && (strobe.optRst || !anyRst)) optQ <= wrData & OPT_KEEP_MASK;
      else if (anyRst)                                optQ <= 8'h00;

      // device control bits
      if (strobe.ctlWr && (strobe.ctlRst || !anyRst)) begin
        ienQ  <= devCtlIen;
        srstQ <= devCtlSrst;
      end else if (anyRst) begin
        ienQ  <= 1'b0;
        srstQ <= 1'b0;
      end

      // status: held bits plus loaded bits, irq bit tracks the drive
      if (anyRst)             statQ <= 8'h00;
      else if (strobe.statWr) statQ <= (statQ & STAT_HOLD_MASK) | (wrData & STAT_LOAD_MASK);
      statQ[STAT_BIT_IRQ] <= drvIrq;

      // ready flag raised by a power-down change
      if (anyRst) readyQ <= 1'b0;
      else if (strobe.statWr && (wrData[STAT_BIT_PWRDN] != statQ[STAT_BIT_PWRDN])) readyQ <= 1'b1;
    end
  end

  always_comb begin
    case (rdSel)
      SEL_ROM:  rdData = romData;
      SEL_OPT:  rdData = optQ;
      SEL_STAT: rdData = ienQ ? (statQ & ~(8'h01 << STAT_BIT_IRQ)) : statQ;
      SEL_PIN:  rdData = PIN_FIXED_BITS | ({7'h00, readyQ} << PIN_BIT_READY);
      default:  rdData = 8'h00;
    endcase
  end

  assign irqLevel = !statQ[STAT_BIT_IRQ] && !ienQ && !srstQ && !optQ[7];
  assign softRst  = softRstQ;

endmodule

// File: rtl/card_cfg_regs.sv
module card_cfg_regs
  import card_cfg_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int ATTR_BASE = 512,
  parameter int ROM_LEN   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] attrAddr,
  input  logic              attrWrEn,
  input  logic [7:0]        attrWrData,
  input  logic              devCtlWr,
  input  logic              devCtlIen,
  input  logic              devCtlSrst,
  input  logic              drvIrq,
  output logic [7:0]        attrRdData,
  output logic              irqLevel,
  output logic              softRst
);

  cfgStrobe_t strobe;
  rdSel_e     rdSel;
  logic [7:0] romData;

  card_cfg_ctrl #(.ADDR_W(ADDR_W), .ATTR_BASE(ATTR_BASE)) u_ctrl (
    .attrAddr  (attrAddr),
    .attrWrEn  (attrWrEn),
    .optSrstBit(attrWrData[7]),
    .devCtlWr  (devCtlWr),
    .devCtlSrst(devCtlSrst),
    .strobe    (strobe),
    .rdSel     (rdSel)
  );

  card_cfg_info_rom #(.ADDR_W(ADDR_W), .ROM_LEN(ROM_LEN)) u_rom (
    .romAddr(attrAddr),
    .romData(romData)
  );

  card_cfg_dpath u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .rdSel     (rdSel),
    .wrData    (attrWrData),
    .devCtlIen (devCtlIen),
    .devCtlSrst(devCtlSrst),
    .drvIrq    (drvIrq),
    .romData   (romData),
    .rdData    (attrRdData),
    .irqLevel  (irqLevel),
    .softRst   (softRst)
  );

endmodule

// File: rtl/card_cfg_regs_chk.sv
module card_cfg_regs_chk #(
  parameter int ADDR_W    = 10,
  parameter int ATTR_BASE = 512,
  parameter int ROM_LEN   = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] attrAddr,
  input logic              attrWrEn,
  input logic [7:0]        attrWrData,
  input logic              devCtlWr,
  input logic              devCtlIen,
  input logic              devCtlSrst,
  input logic              drvIrq,
  input logic [7:0]        attrRdData,
  input logic              irqLevel,
  input logic              softRst
);

  localparam logic [ADDR_W-1:0] A_OPT  = ADDR_W'(ATTR_BASE);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ATTR_BASE + 2);
  localparam logic [ADDR_W-1:0] A_PIN  = ADDR_W'(ATTR_BASE + 4);
  localparam logic [ADDR_W-1:0] A_SOCK = ADDR_W'(ATTR_BASE + 6);
  localparam logic [ADDR_W-1:0] A_ROME = ADDR_W'(ROM_LEN);

  logic optRstReq;
  logic ctlRstReq;
  assign optRstReq = attrWrEn && (attrAddr == A_OPT) && attrWrData[7];
  assign ctlRstReq = devCtlWr && devCtlSrst;

  p_socket_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    (attrAddr == A_SOCK) |-> (attrRdData == 8'h00));

  p_rom_tail_r2: assert property (@(posedge clk) disable iff (!rstN)
    (attrAddr >= A_ROME && attrAddr < A_OPT) |-> (attrRdData == 8'h00));

  p_opt_store_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(attrWrEn && attrAddr == A_OPT) && !$past(ctlRstReq) && attrAddr == A_OPT)
      |-> (attrRdData == ($past(attrWrData) & 8'hCF)));

  p_stat_hide_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(devCtlWr && devCtlIen && !optRstReq) && attrAddr == A_STAT)
      |-> !attrRdData[1]);

  p_pin_fixed_r6: assert property (@(posedge clk) disable iff (!rstN)
    (attrAddr == A_PIN) |-> ((attrRdData & 8'hDF) == 8'h0C));

  p_irq_drv_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(drvIrq)) |-> !irqLevel);

  p_irq_ctl_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(devCtlWr && (devCtlIen || devCtlSrst) && !optRstReq)) |-> !irqLevel);

  p_soft_src_r9: assert property (@(posedge clk) disable iff (!rstN)
    softRst |-> ($past(rstN) && $past(optRstReq || ctlRstReq)));

  p_soft_cause_r9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(optRstReq || ctlRstReq)) |-> softRst);

endmodule

bind card_cfg_regs card_cfg_regs_chk #(
  .ADDR_W(ADDR_W), .ATTR_BASE(ATTR_BASE), .ROM_LEN(ROM_LEN)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .attrAddr  (attrAddr),
  .attrWrEn  (attrWrEn),
  .attrWrData(attrWrData),
  .devCtlWr  (devCtlWr),
  .devCtlIen (devCtlIen),
  .devCtlSrst(devCtlSrst),
  .drvIrq    (drvIrq),
  .attrRdData(attrRdData),
  .irqLevel  (irqLevel),
  .softRst   (softRst)
);

// File: tb/sim_card_cfg_regs.sv
module sim_card_cfg_regs;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 10;
  localparam int BASE       = 512;
  localparam int ROM_LEN    = 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] attrAddr = '0;
  logic              attrWrEn = 1'b0;
  logic [7:0]        attrWrData = 8'h00;
  logic              devCtlWr = 1'b0;
  logic              devCtlIen = 1'b0;
  logic              devCtlSrst = 1'b0;
  logic              drvIrq = 1'b0;
  logic [7:0]        attrRdData;
  logic              irqLevel;
  logic              softRst;

  int total = 0;
  int bad   = 0;

  // bench model of the architectural state
  logic [7:0] optM  = 8'h00;
  logic [7:0] statM = 8'h00;
  logic       readyM = 1'b0;
  logic       ienM  = 1'b0;
  logic       srstM = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  card_cfg_regs #(.ADDR_W(ADDR_W), .ATTR_BASE(BASE), .ROM_LEN(ROM_LEN)) u0 (
    .clk(clk), .rstN(rstN), .attrAddr(attrAddr), .attrWrEn(attrWrEn),
    .attrWrData(attrWrData), .devCtlWr(devCtlWr), .devCtlIen(devCtlIen),
    .devCtlSrst(devCtlSrst), .drvIrq(drvIrq), .attrRdData(attrRdData),
    .irqLevel(irqLevel), .softRst(softRst)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic rd(input int a, input logic [7:0] exp, input string tag);
    attrAddr = ADDR_W'(a);
    #1;
    chk(tag, attrRdData, exp);
  endtask

  function automatic logic [7:0] statView();
    return ienM ? (statM & 8'hFD) : statM;
  endfunction

  function automatic logic [7:0] pinView();
    return 8'h0C | (readyM ? 8'h20 : 8'h00);
  endfunction

  function automatic logic irqView();
    return !statM[1] && !ienM && !srstM && !optM[7];
  endfunction

  task automatic softClear();
    statM  = statM & 8'h02;
    readyM = 1'b0;
  endtask

  task automatic attrWr(input int a, input logic [7:0] d);
    @(negedge clk);
    attrAddr = ADDR_W'(a); attrWrData = d; attrWrEn = 1'b1;
    @(negedge clk);
    attrWrEn = 1'b0;
    if (a == BASE) begin
      optM = d & 8'hCF;
      if (d[7]) begin softClear(); ienM = 1'b0; srstM = 1'b0; end
    end else if (a == BASE + 2) begin
      if (d[2] != statM[2]) readyM = 1'b1;
      statM = (statM & 8'h82) | (d & 8'h74);
    end
  endtask

  task automatic ctlWr(input logic ien, input logic srst);
    @(negedge clk);
    devCtlWr = 1'b1; devCtlIen = ien; devCtlSrst = srst;
    @(negedge clk);
    devCtlWr = 1'b0;
    ienM = ien; srstM = srst;
    if (srst) begin softClear(); optM = 8'h00; end
  endtask

  task automatic setDrv(input logic v);
    @(negedge clk);
    drvIrq = v;
    @(negedge clk);
    statM[1] = v;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10 reset state
    rd(BASE, 8'h00, "R10 option after reset");
    rd(BASE + 2, 8'h00, "R10 status after reset");
    rd(BASE + 4, 8'h0C, "R10 pins after reset");
    chk("R10 irqLevel after reset", {7'h0, irqLevel}, 8'h01);
    chk("R10 softRst after reset", {7'h0, softRst}, 8'h00);

    // R2 information ROM sweep and ignored writes
    for (int a = 0; a < BASE; a++)
      rd(a, (a < ROM_LEN) ? 8'((a * 37 + 11) & 255) : 8'h00, "R2 rom sweep");
    attrWr(3, 8'hFF);
    attrWr(100, 8'h55);
    rd(3, 8'((3 * 37 + 11) & 255), "R2 rom after write");
    rd(100, 8'h00, "R2 beyond rom after write");
    rd(BASE, 8'h00, "R2 option untouched");

    // R1 socket/copy and holes
    attrWr(BASE + 6, 8'hFF);
    rd(BASE + 6, 8'h00, "R1 socket reads zero");
    rd(BASE + 1, 8'h00, "R1 odd hole");
    rd(BASE + 8, 8'h00, "R1 hole above");
    rd(BASE + 2, statView(), "R1 status untouched");

    // R3 / R9 / R8 option sweep
    for (int v = 0; v < 256; v++) begin
      attrWr(BASE, 8'(v));
      chk("R9 softRst from option", {7'h0, softRst}, {7'h0, v[7]});
      rd(BASE, 8'(v) & 8'hCF, "R3 option readback");
      chk("R8 irq vs option", {7'h0, irqLevel}, {7'h0, irqView()});
    end
    attrWr(BASE, 8'h00);

    // R4 / R7 / R6 status sweep
    for (int v = 0; v < 256; v++) begin
      attrWr(BASE + 2, 8'(v));
      rd(BASE + 2, statView(), "R4 status readback");
      rd(BASE + 4, pinView(), "R7 ready flag");
    end
    attrWr(BASE + 4, 8'h00);
    rd(BASE + 4, pinView(), "R6 pins after write 00");
    attrWr(BASE + 4, 8'hFF);
    rd(BASE + 4, pinView(), "R6 pins after write ff");

    // R4 / R5 / R8 interrupt flag and gating
    setDrv(1'b1);
    rd(BASE + 2, statView(), "R4 drive flag visible");
    chk("R8 irq low with drive flag", {7'h0, irqLevel}, 8'h00);
    ctlWr(1'b1, 1'b0);
    rd(BASE + 2, statView(), "R5 flag hidden");
    chk("R5 bit1 hidden", {7'h0, attrRdData[1]}, 8'h00);
    setDrv(1'b0);
    chk("R8 irq gated by enable", {7'h0, irqLevel}, 8'h00);
    ctlWr(1'b0, 1'b0);
    chk("R8 irq asserted", {7'h0, irqLevel}, {7'h0, irqView()});
    ctlWr(1'b0, 1'b1);
    chk("R9 softRst from control", {7'h0, softRst}, 8'h01);
    chk("R8 irq gated by srst", {7'h0, irqLevel}, 8'h00);
    @(negedge clk);
    chk("R9 softRst one cycle", {7'h0, softRst}, 8'h00);
    rd(BASE, optM, "R9 option cleared by control reset");
    ctlWr(1'b0, 1'b0);

    // R9 soft reset on top of status history
    attrWr(BASE + 2, 8'h74);
    attrWr(BASE + 2, 8'h70);
    rd(BASE + 4, 8'h2C, "R7 ready set before reset");
    ctlWr(1'b1, 1'b0);
    attrWr(BASE, 8'h81);
    chk("R9 pulse from option", {7'h0, softRst}, 8'h01);
    rd(BASE + 2, 8'h00, "R9 status cleared");
    rd(BASE + 4, 8'h0C, "R9 ready cleared");
    rd(BASE, 8'h81, "R9 option keeps reset value");
    chk("R9 enable cleared, option gates irq", {7'h0, irqLevel}, 8'h00);
    @(negedge clk);
    chk("R9 pulse ends", {7'h0, softRst}, 8'h00);
    attrWr(BASE, 8'h00);
    chk("R8 irq back after option cleared", {7'h0, irqLevel}, {7'h0, irqView()});

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule